// File: doc/BRIEF.md
# SPI Slave Framer with Run-of-Ones Recovery

This block is the serial front end of an SPI slave register port. It samples the serial data line on every rising edge of the serial clock while chip select is low. It splits the bit stream into an instruction byte followed by one or more data bytes. Completed write bytes appear as a single-cycle strobe on a parallel register bus. Read data is taken from that bus and shifted out on the serial output. Several frames may follow one another inside one chip-select-low period. Chip select may therefore be tied low permanently, as long as streaming frames are avoided in that mode.

The full register address is the concatenation of a page register and a 6-bit address from the instruction. The framer holds the page register and one enable flag itself. When the flag is set, a run of `RUN_LEN` consecutive ones on the data line forces the frame machine back into a search state and clears the page register. In the search state the machine waits for the first zero, which is the leading bit of a write instruction. This lets a host that has lost bit alignment recover without toggling chip select.

All serial inputs are assumed to be already synchronous to `clk`. A serial clock rising edge is detected as a low-to-high change between two `clk` samples. Consecutive serial clock edges must be at least three `clk` cycles apart.

Top module: `spi_framer`

## Requirements
- R1: After reset, `sdo_o`, `wr_stb_o`, `addr_o` and `wdata_o` are all zero, the page register is 0 and run recovery is disabled.
- R2: Bits are taken MSB first on serial clock rising edges. The instruction byte carries bit 7 = direction (0 write, 1 read), bit 6 = stream, and bits 5:0 = low address. On the edge that completes a write data byte, `wr_stb_o` pulses high for exactly one `clk` cycle, one cycle later. During that pulse, `addr_o` = {page, low address} and `wdata_o` = the byte.
- R3: For a read, `rd_data_i` is captured for the address on `addr_o`. It is shifted out MSB first on `sdo_o`, with each bit valid before the rising edge on which the host samples it. `sdo_o` is 0 whenever chip select is high or no read data byte is in progress.
- R4: After a non-stream frame completes, the next bit begins a new instruction byte without chip select being raised.
- R5: In a stream frame, data bytes repeat until chip select rises. The 6-bit low address advances by one, modulo 64, after each byte.
- R6: A chip select rising edge aborts any partial frame without a strobe. The next frame starts with a fresh instruction byte, and the page register is unchanged.
- R7: A write whose low address is 0x0F, on any page, loads the page register from the low `URA_W` bits of the data byte. The page register forms the upper bits of `addr_o`.
- R8: While recovery is disabled, any number of ones is framed as ordinary instruction and data bits.
- R9: A write of 0x01 to full address 0x002 enables recovery. A write of any other value to 0x002 disables it.
- R10: With recovery enabled, the 73rd consecutive one sampled while chip select is low aborts the frame and clears the page register. The enable flag is kept. A run of 72 ones has no such effect.
- R11: After a recovery, ones are ignored. The first zero is bit 7 of a new instruction byte.
- R12: The run counter restarts on any sampled zero and on chip select high. It saturates at `RUN_LEN` instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csb_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, synchronous to `clk` |
| sdi_i | input | 1 | Serial data from host |
| rd_data_i | input | 8 | Register read data for `addr_o` |
| sdo_o | output | 1 | Serial data to host |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| addr_o | output | URA_W+6 | Register address {page, low} |
| wdata_o | output | 8 | Register write data |

## Verification
If the bit counter slips, the host sees write strobes with shifted data or wrong addresses, and read bytes offset by the slip on `sdo_o`, within the same frame. A run counter that fires early, late or without the enable flag shows on the next write as a wrong page in the upper bits of `addr_o`, or as an extra or missing strobe. A page register or low-address pointer that drifts shows on `addr_o` in the very next strobe cycle. Because the reference model is compared on every `clk`, any divergence is reported in the cycle it first reaches a port.

// File: rtl/spi_fr_pkg.sv
`timescale 1ns/1ps
package spi_fr_pkg;

    localparam int BYTE_W = 8;
    localparam int LOW_W  = 6;
    localparam int CNT3_W = $clog2(BYTE_W);

    localparam logic [LOW_W-1:0]  PAGE_LOW = 6'h0F;
    localparam int                EN_ADDR  = 2;
    localparam logic [BYTE_W-1:0] EN_KEY   = 8'h01;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_HUNT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic             rd;
        logic             stream;
        logic [LOW_W-1:0] low;
    } instr_t;

    function automatic instr_t decode_instr(input logic [BYTE_W-1:0] b);
        return instr_t'(b);
    endfunction

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] cur, input logic bit_in);
        return {cur[BYTE_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/spi_sclk_edge.sv
`timescale 1ns/1ps
module spi_sclk_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic rise_o
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_i;
    end

    assign rise_o = sclk_i & ~sclk_q;
endmodule

// File: rtl/spi_run_det.sv
`timescale 1ns/1ps
module spi_run_det #(
    parameter int RUN_LEN = 73,
    parameter int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csb_i,
    input  logic             rise_i,
    input  logic             sdi_i,
    input  logic             en_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || csb_i) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            if (!sdi_i)             cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = !csb_i && rise_i && sdi_i && en_i && (cnt_q == LAST);
    assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_frame_fsm.sv
`timescale 1ns/1ps
module spi_frame_fsm
    import spi_fr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_i,
    input  logic              rise_i,
    input  logic              sdi_i,
    input  logic              hit_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [LOW_W-1:0]  low_o,
    output logic              wr_stb_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              sdo_o
);
    phase_e            phase;
    logic [CNT3_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] rd_sh;
    instr_t            ins;
    logic [LOW_W-1:0]  low;
    logic              adv_q;
    logic              load_q;
    logic              wr_stb;
    logic [BYTE_W-1:0] wdata;

    logic [BYTE_W-1:0] byte_in;
    instr_t            new_ins;
    logic              last_bit;

    assign byte_in  = shift_in(shreg, sdi_i);
    assign new_ins  = decode_instr(byte_in);
    assign last_bit = (bit_cnt == CNT3_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            rd_sh   <= '0;
            ins     <= '0;
            low     <= '0;
            adv_q   <= 1'b0;
            load_q  <= 1'b0;
            wr_stb  <= 1'b0;
            wdata   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (csb_i) begin
                phase   <= PH_INSTR;
                bit_cnt <= '0;
                adv_q   <= 1'b0;
                load_q  <= 1'b0;
            end else if (hit_i) begin
                phase   <= PH_HUNT;
                bit_cnt <= '0;
                adv_q   <= 1'b0;
                load_q  <= 1'b0;
            end else if (rise_i) begin
                unique case (phase)
                    PH_HUNT: begin
                        if (!sdi_i) begin
                            phase   <= PH_INSTR;
                            bit_cnt <= CNT3_W'(1);
                            shreg   <= '0;
                        end
                    end
                    PH_INSTR: begin
                        shreg   <= byte_in;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            ins    <= new_ins;
                            low    <= new_ins.low;
                            phase  <= PH_DATA;
                            load_q <= new_ins.rd;
                        end
                    end
                    PH_DATA: begin
                        shreg   <= byte_in;
                        rd_sh   <= {rd_sh[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            if (!ins.rd) begin
                                wr_stb <= 1'b1;
                                wdata  <= byte_in;
                            end
                            if (ins.stream) adv_q <= 1'b1;
                            else            phase <= PH_INSTR;
                        end
                    end
                    default: phase <= PH_INSTR;
                endcase
            end else if (adv_q) begin
                low    <= low + 1'b1;
                adv_q  <= 1'b0;
                load_q <= ins.rd;
            end else if (load_q) begin
                rd_sh  <= rd_data_i;
                load_q <= 1'b0;
            end
        end
    end

    assign low_o    = low;
    assign wr_stb_o = wr_stb;
    assign wdata_o  = wdata;
    assign sdo_o    = (phase == PH_DATA) && ins.rd && !csb_i && rd_sh[BYTE_W-1];
endmodule

// File: rtl/spi_ctl_regs.sv
`timescale 1ns/1ps
module spi_ctl_regs
    import spi_fr_pkg::*;
#(
    parameter int URA_W  = 3,
    parameter int ADDR_W = URA_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [URA_W-1:0]  ura_o,
    output logic              en_o
);
    logic [URA_W-1:0] ura_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ura_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (hit_i)
                ura_q <= '0;
            else if (wr_stb_i && addr_i[LOW_W-1:0] == PAGE_LOW)
                ura_q <= wdata_i[URA_W-1:0];
            if (wr_stb_i && addr_i == ADDR_W'(EN_ADDR))
                en_q <= (wdata_i == EN_KEY);
        end
    end

    assign ura_o = ura_q;
    assign en_o  = en_q;
endmodule

// File: rtl/spi_framer.sv
`timescale 1ns/1ps
module spi_framer
    import spi_fr_pkg::*;
#(
    parameter  int URA_W   = 3,
    parameter  int RUN_LEN = 73,
    localparam int ADDR_W  = URA_W + LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csb_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sdo_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic             rise;
    logic             hit;
    logic [RUN_W-1:0] run_cnt;
    logic [LOW_W-1:0] low;
    logic [URA_W-1:0] ura;
    logic             en;

    spi_sclk_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .rise_o (rise)
    );

    spi_run_det #(.RUN_LEN(RUN_LEN), .CNT_W(RUN_W)) u_run (
        .clk    (clk),
        .rst    (rst),
        .csb_i  (csb_i),
        .rise_i (rise),
        .sdi_i  (sdi_i),
        .en_i   (en),
        .hit_o  (hit),
        .cnt_o  (run_cnt)
    );

    spi_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .csb_i     (csb_i),
        .rise_i    (rise),
        .sdi_i     (sdi_i),
        .hit_i     (hit),
        .rd_data_i (rd_data_i),
        .low_o     (low),
        .wr_stb_o  (wr_stb_o),
        .wdata_o   (wdata_o),
        .sdo_o     (sdo_o)
    );

    spi_ctl_regs #(.URA_W(URA_W), .ADDR_W(ADDR_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .hit_i    (hit),
        .wr_stb_i (wr_stb_o),
        .addr_i   (addr_o),
        .wdata_i  (wdata_o),
        .ura_o    (ura),
        .en_o     (en)
    );

    assign addr_o = {ura, low};
endmodule

// File: rtl/spi_framer_chk.sv
`timescale 1ns/1ps
module spi_framer_chk #(
    parameter int URA_W   = 3,
    parameter int RUN_LEN = 73,
    parameter int ADDR_W  = URA_W + 6,
    parameter int RUN_W   = $clog2(RUN_LEN + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              csb_i,
    input logic              sdo_o,
    input logic              wr_stb_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              hit_i,
    input logic [RUN_W-1:0]  run_cnt_i
);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    assert_strobe_addr_held_R5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $stable(addr_o));

    assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        csb_i |-> !sdo_o);

    assert_abort_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        csb_i |=> !wr_stb_o);

    assert_page_cleared_R10: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> (addr_o[ADDR_W-1 -: URA_W] == '0));

    assert_run_saturates_R12: assert property (@(posedge clk) disable iff (rst)
        run_cnt_i <= RUN_W'(RUN_LEN));
endmodule

bind spi_framer spi_framer_chk #(.URA_W(URA_W), .RUN_LEN(RUN_LEN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .csb_i     (csb_i),
    .sdo_o     (sdo_o),
    .wr_stb_o  (wr_stb_o),
    .addr_o    (addr_o),
    .hit_i     (hit),
    .run_cnt_i (run_cnt)
);

// File: tb/spi_framer_tb_top.sv
`timescale 1ns/1ps
module spi_framer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int URA_W      = 3;
    localparam int RUN_LEN    = 73;
    localparam int ADDR_W     = URA_W + 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csb = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [7:0] rd_data;
    logic sdo, wr_stb;
    logic [ADDR_W-1:0] addr;
    logic [7:0] wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = 8'((int'(addr) * 5 + 3) % 256);

    spi_framer #(.URA_W(URA_W), .RUN_LEN(RUN_LEN)) dut_i (
        .clk(clk), .rst(rst), .csb_i(csb), .sclk_i(sclk), .sdi_i(sdi),
        .rd_data_i(rd_data), .sdo_o(sdo), .wr_stb_o(wr_stb),
        .addr_o(addr), .wdata_o(wdata)
    );

    int n_tests = 0;
    int n_fail = 0;
    string req = "R1";

    task automatic check(string r, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // behavioural reference model, one step per clk
    int m_ph, m_bits, m_byte, m_rd, m_st, m_low, m_ura, m_en, m_run;
    int m_adv, m_load, m_rdsh, m_wr, m_wd, m_prev;
    bit m_go = 1'b0;

    always @(posedge clk) begin
        int rise, hit, o_wr, o_addr, o_wd, b;
        if (rst) begin
            m_ph = 0; m_bits = 0; m_byte = 0; m_rd = 0; m_st = 0; m_low = 0;
            m_ura = 0; m_en = 0; m_run = 0; m_adv = 0; m_load = 0; m_rdsh = 0;
            m_wr = 0; m_wd = 0; m_prev = 0; m_go = 1'b1;
        end else begin
            rise = (sclk && m_prev == 0) ? 1 : 0;
            m_prev = sclk;
            o_wr = m_wr; o_addr = m_ura * 64 + m_low; o_wd = m_wd;
            hit = (!csb && rise == 1 && sdi && m_en == 1 && m_run == RUN_LEN - 1) ? 1 : 0;
            if (csb) m_run = 0;
            else if (rise == 1) m_run = sdi ? ((m_run < RUN_LEN) ? m_run + 1 : RUN_LEN) : 0;
            if (hit == 1) m_ura = 0;
            else if (o_wr == 1 && (o_addr % 64) == 15) m_ura = o_wd % (1 << URA_W);
            if (o_wr == 1 && o_addr == 2) m_en = (o_wd == 1) ? 1 : 0;
            m_wr = 0;
            if (csb) begin
                m_ph = 0; m_bits = 0; m_adv = 0; m_load = 0;
            end else if (hit == 1) begin
                m_ph = 2; m_bits = 0; m_adv = 0; m_load = 0;
            end else if (rise == 1) begin
                b = (m_byte * 2 + int'(sdi)) % 256;
                if (m_ph == 2) begin
                    if (!sdi) begin m_ph = 0; m_bits = 1; m_byte = 0; end
                end else if (m_ph == 0) begin
                    m_byte = b; m_bits++;
                    if (m_bits == 8) begin
                        m_bits = 0; m_rd = b / 128; m_st = (b / 64) % 2;
                        m_low = b % 64; m_ph = 1; m_load = m_rd;
                    end
                end else begin
                    m_byte = b; m_rdsh = (m_rdsh * 2) % 256; m_bits++;
                    if (m_bits == 8) begin
                        m_bits = 0;
                        if (m_rd == 0) begin m_wr = 1; m_wd = b; end
                        if (m_st == 1) m_adv = 1; else m_ph = 0;
                    end
                end
            end else if (m_adv == 1) begin
                m_low = (m_low + 1) % 64; m_adv = 0; m_load = m_rd;
            end else if (m_load == 1) begin
                m_rdsh = ((m_ura * 64 + m_low) * 5 + 3) % 256; m_load = 0;
            end
        end
    end

    // per-clock comparison and strobe monitor
    int n_wr = 0;
    int last_addr = 0;
    int last_wd = 0;

    always @(negedge clk) begin
        if (!rst && m_go) begin
            check(req, "sdo", int'(sdo),
                  (m_ph == 1 && m_rd == 1 && !csb) ? (m_rdsh / 128) % 2 : 0);
            check(req, "wr_stb", int'(wr_stb), m_wr);
            check(req, "addr", int'(addr), m_ura * 64 + m_low);
            check(req, "wdata", int'(wdata), m_wd);
            if (wr_stb) begin
                n_wr++; last_addr = int'(addr); last_wd = int'(wdata);
            end
        end
    end

    logic [7:0] rx;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_bit(bit b);
        sdi = b;
        repeat (4) tick();
        rx = {rx[6:0], sdo};
        sclk = 1'b1;
        repeat (4) tick();
        sclk = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic ones(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic cs_low();
        csb = 1'b0; repeat (2) tick();
    endtask

    task automatic cs_high();
        csb = 1'b1; repeat (3) tick();
    endtask

    task automatic wr_frame(logic [5:0] low, logic [7:0] d);
        cs_low(); send_byte({2'b00, low}); send_byte(d); cs_high();
    endtask

    task automatic expect_wr(string r, int cnt, int a, int d);
        check(r, "strobe count", n_wr, cnt);
        check(r, "strobe addr", last_addr, a);
        check(r, "strobe data", last_wd, d);
        n_wr = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        req = "R1";
        check("R1", "reset sdo", int'(sdo), 0);
        check("R1", "reset wr_stb", int'(wr_stb), 0);
        check("R1", "reset addr", int'(addr), 0);
        check("R1", "reset wdata", int'(wdata), 0);

        req = "R2"; n_wr = 0;
        wr_frame(6'h05, 8'hA5);
        expect_wr("R2", 1, 'h005, 'hA5);

        req = "R3";
        cs_low(); send_byte(8'h89); send_byte(8'h00); cs_high();
        check("R3", "read byte", int'(rx), 'h30);

        req = "R4"; n_wr = 0;
        cs_low(); send_byte(8'h11); send_byte(8'h3C);
        send_byte(8'h92); send_byte(8'h00); cs_high();
        check("R4", "read after write", int'(rx), 'h5D);
        expect_wr("R4", 1, 'h011, 'h3C);

        req = "R5";
        cs_low(); send_byte(8'h7E); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); cs_high();
        expect_wr("R5", 3, 'h000, 'h03);

        req = "R6";
        cs_low(); send_byte(8'h07); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); cs_high();
        check("R6", "aborted frame strobes", n_wr, 0);
        wr_frame(6'h07, 8'h99);
        expect_wr("R6", 1, 'h007, 'h99);

        req = "R7";
        wr_frame(6'h0F, 8'h05);
        wr_frame(6'h10, 8'h77);
        expect_wr("R7", 2, 'h150, 'h77);
        cs_low(); send_byte(8'h81); send_byte(8'h00); cs_high();
        check("R7", "paged read", int'(rx), 'h48);

        req = "R8";
        cs_low(); ones(80); cs_high();
        wr_frame(6'h20, 8'h11);
        expect_wr("R8", 1, 'h160, 'h11);

        req = "R9";
        wr_frame(6'h0F, 8'h00);
        wr_frame(6'h02, 8'h01);
        wr_frame(6'h0F, 8'h03);
        n_wr = 0;

        req = "R10";
        cs_low(); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        ones(73);
        req = "R11";
        ones(5); send_byte(8'h05); send_byte(8'hC3); cs_high();
        expect_wr("R10", 9, 'h005, 'hC3);

        req = "R10";
        wr_frame(6'h0F, 8'h02);
        cs_low(); ones(72); send_bit(1'b0); cs_high();
        n_wr = 0;
        wr_frame(6'h03, 8'h44);
        expect_wr("R10", 1, 'h083, 'h44);

        req = "R12";
        cs_low(); ones(40); cs_high(); cs_low(); ones(40); cs_high();
        wr_frame(6'h04, 8'h55);
        expect_wr("R12", 1, 'h084, 'h55);
        cs_low(); ones(50); send_bit(1'b0); ones(50); cs_high();
        n_wr = 0;
        wr_frame(6'h06, 8'h66);
        expect_wr("R12", 1, 'h086, 'h66);

        req = "R9";
        wr_frame(6'h0F, 8'h00);
        wr_frame(6'h02, 8'h00);
        wr_frame(6'h0F, 8'h01);
        cs_low(); ones(80); cs_high();
        n_wr = 0;
        wr_frame(6'h01, 8'h21);
        expect_wr("R9", 1, 'h041, 'h21);

        summary();
        $finish;
    end
endmodule